// File: doc/BRIEF.md
# Processor Status and Interrupt Control Register

This block holds one status byte for a small processor. The byte packs two carry flags, two interrupt enables, two pending flags, a live busy indication from the serial shifter and a global interrupt enable. The CPU reads the byte at any time and can write it, except for the busy bit, which is read-only. Dedicated strobes set or clear both carry flags together. Separate strobes set or clear the global enable, and a return-from-interrupt strobe sets it again.

Two event sources feed the pending flags. The first is an external interrupt pin. It passes through a synchronizer, and a polarity control selects whether a rising or a falling edge counts. The second is a one-cycle timer event, raised on an underflow or a capture edge. At every instruction start the block decides whether an interrupt is taken. A taken interrupt gives a one-cycle request pulse and clears the global enable. The decision uses the register contents from before that cycle's updates. A single-cycle write that clears an enable in the same cycle therefore does not stop the interrupt. All pins are plain control and status signals. There is no streaming interface, so no valid/ready handshake or back-pressure applies.

Top module: `psw_status_reg`

## Requirements
- R1: After reset every stored bit (HC, C, TPND, ENTI, IPND, ENI, GIE) reads 0 and `irq_req` is 0.
- R2: `rd_data` packs bit 7 HC, bit 6 C, bit 5 TPND, bit 4 ENTI, bit 3 IPND, bit 2 BUSY, bit 1 ENI, bit 0 GIE. A cycle with `wr_en` high loads every stored bit from the same position of `wr_data`, unless a higher-priority source named below acts on that bit.
- R3: Bit 2 of `rd_data` always equals `shift_busy` in the same cycle. Writes to bit 2 have no effect.
- R4: `carry_set` sets both HC and C at the next edge. `carry_clr` clears both. `carry_set` wins over `carry_clr`, and both win over a write.
- R5: With `edge_pol`=0 a rising edge on `ext_pin` counts, and with `edge_pol`=1 a falling edge counts. After the 2-stage synchronizer, IPND becomes 1 at the third rising clock edge after the pin changes, and not before.
- R6: A cycle with `tmr_event` high sets TPND at the next edge.
- R7: A pending bit (TPND, IPND) is cleared only by a write of 0. An event in the same cycle as that write wins, and the bit stays 1.
- R8: `irq_req` is 1 for exactly the cycle after an `instr_start` cycle in which GIE=1 and ((IPND and ENI) or (TPND and ENTI)) held. Otherwise it is 0.
- R9: GIE priority at an edge, highest first: a taken interrupt clears it; `ret_irq` or `gie_set` sets it; `gie_clr` clears it; a write loads it.
- R10: When a write clears ENI or ENTI in the same `instr_start` cycle in which an interrupt qualifies, the interrupt is still taken, and the enable reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| edge_pol | input | 1 | Active edge select: 0 rising, 1 falling |
| tmr_event | input | 1 | Timer underflow or capture pulse |
| shift_busy | input | 1 | Serial shifter busy status |
| wr_en | input | 1 | CPU write strobe for the status byte |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Status byte read value |
| carry_set | input | 1 | Set HC and C |
| carry_clr | input | 1 | Clear HC and C |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| ret_irq | input | 1 | Return from interrupt; sets global enable |
| instr_start | input | 1 | Instruction boundary strobe |
| irq_req | output | 1 | Interrupt taken, one-cycle pulse |

## Verification
The hardest case to reach from the ports is the race. An enable must be cleared by a write in the same cycle as an instruction boundary, while a pending, enabled interrupt sits behind a set global enable. A second race is an event edge that lands in the same cycle as the write clearing its pending bit. The bench sets up both races with directed sequences. It places the pin change exactly three clocks ahead of the clearing write, so the synchronized edge and the write meet. Long random runs also hit these races by chance, because writes, boundaries and events are all frequent.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic hc;
    logic c;
    logic tpnd;
    logic enti;
    logic ipnd;
    logic busy;
    logic eni;
    logic gie;
  } status_t;
endpackage

// File: rtl/psw_edge_sync.sv
module psw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic falling,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign edge_hit = falling ? (prev_q & ~cur) : (~prev_q & cur);

  // An edge requires that the synchronized level changed since the last cycle
  assert_edge_is_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (prev_q != cur));
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gie,
  input  logic ipnd,
  input  logic eni,
  input  logic tpnd,
  input  logic enti,
  input  logic instr_start,
  output logic take,
  output logic irq_req
);
  logic qualified;

  assign qualified = gie & ((ipnd & eni) | (tpnd & enti));
  assign take      = instr_start & qualified;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= take;
  end

  assert_req_needs_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(instr_start) && $past(gie));
  assert_req_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req || $past(instr_start));
endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_pin,
  input  logic       edge_pol,
  input  logic       tmr_event,
  input  logic       shift_busy,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       carry_set,
  input  logic       carry_clr,
  input  logic       gie_set,
  input  logic       gie_clr,
  input  logic       ret_irq,
  input  logic       instr_start,
  output logic       irq_req
);
  import psw_pkg::*;

  status_t wr_s;
  status_t rd_s;
  logic hc_q, c_q, tpnd_q, enti_q, ipnd_q, eni_q, gie_q;
  logic ext_hit;
  logic take;

  assign wr_s = status_t'(wr_data);

  psw_edge_sync #(.STAGES(SYNC_STAGES)) i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .falling  (edge_pol),
    .edge_hit (ext_hit)
  );

  psw_irq_gate i_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie         (gie_q),
    .ipnd        (ipnd_q),
    .eni         (eni_q),
    .tpnd        (tpnd_q),
    .enti        (enti_q),
    .instr_start (instr_start),
    .take        (take),
    .irq_req     (irq_req)
  );

  // Carry pair: dedicated strobes override CPU write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_q <= 1'b0;
      c_q  <= 1'b0;
    end else if (carry_set) begin
      hc_q <= 1'b1;
      c_q  <= 1'b1;
    end else if (carry_clr) begin
      hc_q <= 1'b0;
      c_q  <= 1'b0;
    end else if (wr_en) begin
      hc_q <= wr_s.hc;
      c_q  <= wr_s.c;
    end
  end

  // Pending flags: an event beats a clearing write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpnd_q <= 1'b0;
      ipnd_q <= 1'b0;
    end else begin
      if (tmr_event)  tpnd_q <= 1'b1;
      else if (wr_en) tpnd_q <= wr_s.tpnd;
      if (ext_hit)    ipnd_q <= 1'b1;
      else if (wr_en) ipnd_q <= wr_s.ipnd;
    end
  end

  // Enables: written only by the CPU
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enti_q <= 1'b0;
      eni_q  <= 1'b0;
    end else if (wr_en) begin
      enti_q <= wr_s.enti;
      eni_q  <= wr_s.eni;
    end
  end

  // Global enable: taking an interrupt has top priority
  always_ff @(posedge clk) begin
    if (!rst_n)                  gie_q <= 1'b0;
    else if (take)               gie_q <= 1'b0;
    else if (ret_irq || gie_set) gie_q <= 1'b1;
    else if (gie_clr)            gie_q <= 1'b0;
    else if (wr_en)              gie_q <= wr_s.gie;
  end

  always_comb begin
    rd_s.hc   = hc_q;
    rd_s.c    = c_q;
    rd_s.tpnd = tpnd_q;
    rd_s.enti = enti_q;
    rd_s.ipnd = ipnd_q;
    rd_s.busy = shift_busy;
    rd_s.eni  = eni_q;
    rd_s.gie  = gie_q;
    rd_data   = rd_s;
  end

  always_comb begin
    if (rst_n && wr_en && wr_s.busy && !shift_busy)
      assert_busy_not_writable_R3: assert (!rd_data[2]);
  end

  assert_carry_set_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_set |=> hc_q && c_q);
  assert_tmr_sets_tpnd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_event |=> tpnd_q);
  assert_pend_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ipnd_q) |=> ipnd_q);
  assert_take_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !gie_q);
endmodule

// File: tb/test_psw_status_reg.sv
module test_psw_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 0, pol = 0, tmr = 0, busy = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic cset = 0, cclr = 0, gset = 0, gclr = 0, reti = 0, istart = 0;
  logic [7:0] rd_data;
  logic irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic m_hc, m_c, m_tp, m_en_t, m_ip, m_en_i, m_gie, m_irq;
  logic s1, s2, sp;

  always #4 clk = ~clk;

  psw_status_reg i_psw_status_reg (
    .clk(clk), .rst_n(rst_n), .ext_pin(pin), .edge_pol(pol),
    .tmr_event(tmr), .shift_busy(busy), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .carry_set(cset), .carry_clr(cclr),
    .gie_set(gset), .gie_clr(gclr), .ret_irq(reti),
    .instr_start(istart), .irq_req(irq_req)
  );

  function automatic logic [7:0] model_byte();
    return {m_hc, m_c, m_tp, m_en_t, m_ip, busy, m_en_i, m_gie};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_hc, m_c, m_tp, m_en_t, m_ip, m_en_i, m_gie, m_irq} = '0;
    {s1, s2, sp} = '0;
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = model_byte();
    check("R4 carry pair", {6'd0, rd_data[7:6]}, {6'd0, e[7:6]});
    check("R7 pending", {6'd0, rd_data[5], rd_data[3]}, {6'd0, e[5], e[3]});
    check("R2 enables", {6'd0, rd_data[4], rd_data[1]}, {6'd0, e[4], e[1]});
    check("R3 busy", {7'd0, rd_data[2]}, {7'd0, busy});
    check("R9 gie", {7'd0, rd_data[0]}, {7'd0, e[0]});
    check("R8 irq_req", {7'd0, irq_req}, {7'd0, m_irq});
  endtask

  // inputs already driven; advance one clock and check at the next negedge
  task automatic step();
    logic det, take;
    logic n_hc, n_c, n_tp, n_et, n_ip, n_ei, n_g;
    det  = pol ? (sp & ~s2) : (~sp & s2);
    take = istart & m_gie & ((m_ip & m_en_i) | (m_tp & m_en_t));
    n_hc = cset ? 1'b1 : cclr ? 1'b0 : wr_en ? wr_data[7] : m_hc;
    n_c  = cset ? 1'b1 : cclr ? 1'b0 : wr_en ? wr_data[6] : m_c;
    n_tp = tmr ? 1'b1 : wr_en ? wr_data[5] : m_tp;
    n_et = wr_en ? wr_data[4] : m_en_t;
    n_ip = det ? 1'b1 : wr_en ? wr_data[3] : m_ip;
    n_ei = wr_en ? wr_data[1] : m_en_i;
    n_g  = take ? 1'b0 : (reti | gset) ? 1'b1 : gclr ? 1'b0 : wr_en ? wr_data[0] : m_gie;
    @(posedge clk);
    #1;
    {m_hc, m_c, m_tp, m_en_t, m_ip, m_en_i, m_gie, m_irq} =
      {n_hc, n_c, n_tp, n_et, n_ip, n_ei, n_g, take};
    sp = s2; s2 = s1; s1 = pin;
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    {tmr, wr_en, cset, cclr, gset, gclr, reti, istart} = '0;
  endtask

  task automatic write(logic [7:0] d);
    quiet(); wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check("R1 reset byte", rd_data, 8'h00);
    check("R1 reset irq", {7'd0, irq_req}, 8'h00);

    // R2 layout via write/readback; BUSY bit write ignored (R3)
    write(8'b1101_1111);
    check("R2 write readback", rd_data, 8'b1101_1011);
    busy = 1; quiet(); step();
    check("R3 busy live", {7'd0, rd_data[2]}, 8'h01);
    busy = 0;
    write(8'h00);

    // R4 carry strobes
    quiet(); cset = 1; cclr = 1; wr_en = 1; wr_data = 8'h00; step();
    check("R4 set wins", {6'd0, rd_data[7:6]}, 8'h03);
    quiet(); cclr = 1; wr_en = 1; wr_data = 8'hC0; step();
    check("R4 clear over write", {6'd0, rd_data[7:6]}, 8'h00);

    // R6 timer
    quiet(); tmr = 1; step(); quiet();
    check("R6 tpnd set", {7'd0, rd_data[5]}, 8'h01);
    write(8'h00);

    // R5 rising edge timing
    pol = 0; pin = 1; quiet(); step();
    check("R5 not yet 1", {7'd0, rd_data[3]}, 8'h00);
    step();
    check("R5 not yet 2", {7'd0, rd_data[3]}, 8'h00);
    step();
    check("R5 rising sets ipnd", {7'd0, rd_data[3]}, 8'h01);
    write(8'h00);
    // falling edge with pol=1; clearing write meets the edge (R7)
    pol = 1; pin = 0; quiet(); step(); step();
    wr_en = 1; wr_data = 8'h00; step(); wr_en = 0;
    check("R7 edge beats clear", {7'd0, rd_data[3]}, 8'h01);
    write(8'h00);
    check("R7 write clears", {7'd0, rd_data[3]}, 8'h00);

    // R10 race: pending + enabled + gie, clear ENI with write at instr_start
    write(8'b0000_1011);
    quiet(); istart = 1; wr_en = 1; wr_data = 8'b0000_1001; step(); quiet();
    check("R10 irq taken", {7'd0, irq_req}, 8'h01);
    check("R10 eni cleared", {7'd0, rd_data[1]}, 8'h00);
    check("R9 take clears gie", {7'd0, rd_data[0]}, 8'h00);
    quiet(); step();
    check("R8 single pulse", {7'd0, irq_req}, 8'h00);
    quiet(); reti = 1; gclr = 1; step(); quiet();
    check("R9 reti sets gie", {7'd0, rd_data[0]}, 8'h01);
    quiet(); istart = 1; step(); quiet();
    check("R8 no request when disabled", {7'd0, irq_req}, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tmr    = ($urandom % 10) == 0;
      pin    = ($urandom % 4) == 0 ? ~pin : pin;
      pol    = ($urandom % 50) == 0 ? ~pol : pol;
      busy   = $urandom;
      wr_en  = ($urandom % 6) == 0;
      wr_data = $urandom;
      cset   = ($urandom % 12) == 0;
      cclr   = ($urandom % 12) == 0;
      gset   = ($urandom % 8) == 0;
      gclr   = ($urandom % 10) == 0;
      reti   = ($urandom % 15) == 0;
      istart = ($urandom % 3) == 0;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule